// File: doc/BRIEF.md
# Masked Level Interrupt Aggregator

This block gathers a set of level-sensitive interrupt request lines (sixteen by default) into a status register that is refreshed on every clock. It combines the status with a software-programmed enable mask and drives a single combined interrupt request towards the processor. The lines are assumed to be synchronous to the block clock.

Software uses a small register window that is 16 bits wide. The enable mask is at byte offset 2. At byte offset 0 there is a read-only vector register. This register does not return a bitmap. It returns an encoded number that identifies the lowest-numbered line that is both asserted and enabled, so an interrupt handler can dispatch with a single load. The block has no edge detection, no programmable priority and no nesting. The lowest-numbered line always wins.

Top module: `irq_masked_ctrl`

## Requirements
- R1: Under synchronous active-high reset, the status register clears to 0, the enable mask loads 0x0010 (only line 4 enabled), and both `irq_out` and `bus_rdata` are 0.
- R2: Each status bit copies its input line at every rising clock edge. A high line sets the bit and a low line clears it, with no memory of earlier levels.
- R3: `irq_out` is a register that is high exactly when (status AND mask) is nonzero. It reflects an input change or a mask write at the same clock edge that updates the status or mask, which is one clock after the change is presented.
- R4: A read of byte offset 0x0 returns (n+1) << 2 in `bus_rdata`, where n is the lowest-numbered line that is both pending and enabled. It returns 0 when no enabled line is pending. The value reflects the register state at the edge that samples `bus_rd`.
- R5: Byte offset 0x2 holds the enable mask, with bit i enabling line i. A write there replaces the whole mask at the next edge, and a read returns the mask.
- R6: Writes to offset 0x0 or to any offset other than 0x2 change neither the mask nor `irq_out`.
- R7: Reads of any offset other than 0x0 and 0x2 return 0. In a cycle with no read, `bus_rdata` is 0.
- R8: A line whose mask bit is 0 is invisible. It cannot raise `irq_out`, and it cannot be reported in the vector, even when its number is lower than the number of an enabled pending line.
- R9: Read data is registered. `bus_rdata` carries the result in the cycle after the one in which `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Level interrupt request lines, synchronous to clk |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
The bench builds the block with its default parameters: sixteen lines, a 16-bit data path and a 12-bit offset. At that size it can walk every line position on its own and every lowest-winner position in a fully populated request word. It also walks every one-hot mask against all lines raised and checks each encoded vector against (n+1)<<2. The same configuration covers the reset mask of line 4 alone, with a lower line masked off. It also covers ignored writes at the vector offset and at unused offsets, and zero reads from unmapped offsets.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // byte offsets of the register window
  localparam int unsigned VEC_OFS  = 0;
  localparam int unsigned MASK_OFS = 2;
  // enable mask value after reset
  localparam int unsigned MASK_RST = 'h0010;
  // left shift applied to (index + 1) in the vector register
  localparam int unsigned VEC_SHIFT = 2;
endpackage

// File: rtl/irq_level_capture.sv
module irq_level_capture #(
  parameter int N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] status_q
);
  // one flop per line, level copied every clock
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) status_q[g] <= 1'b0;
      else     status_q[g] <= lines_i[g];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int          N_LINES  = 16,
  parameter int unsigned RST_VAL  = 'h0010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wr_val,
  output logic [N_LINES-1:0] mask_q,
  output logic [N_LINES-1:0] mask_next
);
  always_comb mask_next = wr_en ? wr_val : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= N_LINES'(RST_VAL);
    else     mask_q <= mask_next;
  end
endmodule

// File: rtl/irq_lowest_encoder.sv
module irq_lowest_encoder #(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 16,
  parameter int SHIFT   = 2,
  localparam int IDX_W  = $clog2(N_LINES + 1)
) (
  input  logic [N_LINES-1:0] pend_i,
  output logic [DATA_W-1:0]  vec_o
);
  logic [IDX_W-1:0] num;

  // scan from the top so the lowest set bit is the last to assign
  always_comb begin
    num = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pend_i[i]) num = IDX_W'(i + 1);
    end
  end

  assign vec_o = DATA_W'(num) << SHIFT;
endmodule

// File: rtl/irq_masked_ctrl.sv
module irq_masked_ctrl #(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  import irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

  logic [N_LINES-1:0] status_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] mask_next;
  logic [N_LINES-1:0] pend;
  logic [DATA_W-1:0]  vec;
  logic               mask_wr;
  logic [DATA_W-1:0]  rd_mux;

  assign mask_wr = bus_wr && (bus_addr == A_MASK);

  irq_level_capture #(.N_LINES(N_LINES)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .lines_i  (irq_in),
    .status_q (status_q)
  );

  irq_mask_reg #(.N_LINES(N_LINES), .RST_VAL(MASK_RST)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (mask_wr),
    .wr_val    (bus_wdata[N_LINES-1:0]),
    .mask_q    (mask_q),
    .mask_next (mask_next)
  );

  assign pend = status_q & mask_q;

  irq_lowest_encoder #(.N_LINES(N_LINES), .DATA_W(DATA_W), .SHIFT(VEC_SHIFT)) u_enc (
    .pend_i (pend),
    .vec_o  (vec)
  );

  // output follows the next-state values so it lands with status and mask
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(irq_in & mask_next);
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_VEC)       rd_mux = vec;
    else if (bus_addr == A_MASK) rd_mux = DATA_W'(mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/irq_masked_ctrl_chk.sv
module irq_masked_ctrl_chk #(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] irq_in,
  input logic [N_LINES-1:0] status,
  input logic [N_LINES-1:0] mask,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_out
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  assert_status_follows_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> status == $past(irq_in));

  assert_out_matches_R3: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(status & mask));

  assert_mask_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(2)) |=> mask == $past(bus_wdata[N_LINES-1:0]));

  assert_other_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (!(bus_wr && bus_addr == ADDR_W'(2))) |=> $stable(mask));

  assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || (bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(2))) |=> bus_rdata == '0);

  assert_vec_none_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(0) && (status & mask) == '0) |=> bus_rdata == '0);

  assert_vec_lowbits_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(0)) |=> bus_rdata[1:0] == 2'b00);
endmodule

bind irq_masked_ctrl irq_masked_ctrl_chk #(
  .N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .irq_in    (irq_in),
  .status    (status_q),
  .mask      (mask_q),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out)
);

// File: tb/irq_masked_ctrl_tb_top.sv
module irq_masked_ctrl_tb_top;
  localparam int N  = 16;
  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [N-1:0] m_mask;

  always #10 clk = ~clk;

  irq_masked_ctrl #(.N_LINES(N), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [DW-1:0] exp_vec(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return DW'((i + 1) * 4);
    return '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [N-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq_out", DW'(irq_out), 0);
    check("R1 rdata", bus_rdata, 0);
    rst = 1'b0;
    bus_read(12'h2, rv); check("R1 mask", rv, 16'h0010);
    bus_read(12'h0, rv); check("R1 vec", rv, 0);
    m_mask = 16'h0010;

    // R8: everything but line 4 raised under reset mask
    set_in(16'hFFEF); check("R8 out masked", DW'(irq_out), 0);
    bus_read(12'h0, rv); check("R8 vec masked", rv, 0);
    // R8: line 4 wins although lower lines pending but masked
    set_in(16'hFFFF); check("R8 out", DW'(irq_out), 1);
    bus_read(12'h0, rv); check("R8 vec", rv, 16'd20);

    // R5: enable all
    bus_write(12'h2, 16'hFFFF); m_mask = '1;
    bus_read(12'h2, rv); check("R5 mask readback", rv, 16'hFFFF);

    // R2/R3/R4: each line alone
    for (int i = 0; i < N; i++) begin
      set_in(N'(1) << i);
      check("R3 single out", DW'(irq_out), 1);
      bus_read(12'h0, rv); check("R4 single vec", rv, exp_vec(N'(1) << i));
      set_in('0);
      check("R2 line low", DW'(irq_out), 0);
    end

    // R4: lowest wins with all higher lines also raised
    for (int i = 0; i < N; i++) begin
      set_in(16'hFFFF << i);
      bus_read(12'h0, rv); check("R4 lowest", rv, DW'((i + 1) * 4));
    end

    // R8/R5: one-hot masks against all lines raised
    set_in(16'hFFFF);
    for (int j = 0; j < N; j++) begin
      bus_write(12'h2, DW'(1) << j); m_mask = N'(1) << j;
      check("R3 out after mask write", DW'(irq_out), 1);
      bus_read(12'h0, rv); check("R8 onehot mask vec", rv, exp_vec(16'hFFFF & m_mask));
    end
    bus_write(12'h2, 16'h0000); m_mask = '0;
    check("R3 mask zero drops out", DW'(irq_out), 0);
    bus_read(12'h0, rv); check("R4 none pending", rv, 0);

    // R6: ignored writes
    bus_write(12'h2, 16'h0300); m_mask = 16'h0300;
    set_in(16'h0100);
    check("R3 out", DW'(irq_out), 1);
    bus_write(12'h0, 16'h0000);
    check("R6 out after vec write", DW'(irq_out), 1);
    bus_write(12'h4, 16'h0000);
    bus_write(12'hFFE, 16'hFFFF);
    bus_write(12'h3, 16'h0000);
    bus_read(12'h2, rv); check("R6 mask kept", rv, 16'h0300);
    check("R6 out kept", DW'(irq_out), 1);

    // R7: unmapped reads
    bus_read(12'h4, rv);   check("R7 read 4", rv, 0);
    bus_read(12'h1, rv);   check("R7 read 1", rv, 0);
    bus_read(12'h6, rv);   check("R7 read 6", rv, 0);
    bus_read(12'hFFE, rv); check("R7 read ffe", rv, 0);
    @(negedge clk); check("R7 idle rdata", bus_rdata, 0);

    // R9: read result appears exactly one cycle after strobe
    @(negedge clk); bus_rd = 1'b1; bus_addr = 12'h0;
    check("R9 before edge", bus_rdata, 0);
    @(negedge clk); bus_rd = 1'b0;
    check("R9 after edge", bus_rdata, 16'd36);
    @(negedge clk); check("R9 cleared", bus_rdata, 0);

    // R2: status follows a falling level next clock
    set_in(16'h0000); check("R2 fall", DW'(irq_out), 0);
    bus_read(12'h0, rv); check("R2 vec after fall", rv, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule